// File: doc/BRIEF.md
# Processor Clock and Reset Generator

This block turns one fast oscillator into the clocks and control lines that a small processor board needs. The processor clock is the oscillator divided by three. It is high for one oscillator period and low for two. A peripheral clock runs at half the processor clock rate with equal high and low times. A buffered copy of whichever oscillator source is selected is also brought out. A select input chooses between the crystal path and an external frequency input.

An active-low reset request is synchronised and turned into an active-high processor reset. That reset only ever changes on a falling edge of the processor clock. When the request is first seen, the dividers restart from a fixed phase. Two wait-request inputs, each gated by its own active-low enable, are merged into one READY output. READY is synchronised to the processor clock through either one or two stages.

All logic runs on the selected oscillator. The processor-clock edges are used as one-cycle enables. Amplifying the crystal and debouncing the reset switch are done outside the block.

Top module: `cpu_clock_reset_gen`

## Requirements
- R1: `cpu_clk_o` repeats a pattern of one oscillator period high followed by two oscillator periods low.
- R2: `periph_clk_o` toggles only on a rising edge of `cpu_clk_o`, and it toggles on every such edge, so it is high for three oscillator periods and low for three.
- R3: `osc_o` follows `ext_clk_i` when `src_ext_i` is 1 and follows `xtal_clk_i` when `src_ext_i` is 0.
- R4: While `rst_req_n_i` is held low, `cpu_reset_o` is 1. After release, `cpu_reset_o` is still 1 two oscillator edges later and is 0 no later than the fifth oscillator edge.
- R5: `cpu_reset_o` changes only on the oscillator edge where `cpu_clk_o` goes from 1 to 0.
- R6: When `rst_req_n_i` falls, the dividers restart on the third oscillator edge after it. On that edge and the two edges after it, both clocks are 0. On the sixth edge, both clocks become 1.
- R7: The qualified request is (`rdy_a_i` AND NOT `rdy_a_en_n_i`) OR (`rdy_b_i` AND NOT `rdy_b_en_n_i`). A ready input whose enable is high has no effect on `cpu_ready_o`.
- R8: With `rdy_dual_stage_i` = 0, `cpu_ready_o` takes the qualified request sampled at each rising edge of `cpu_clk_o` and changes only on that edge.
- R9: With `rdy_dual_stage_i` = 1, `cpu_ready_o` changes only on a falling edge of `cpu_clk_o`. It takes the value that was captured at the rising edge just before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk_i | input | 1 | Oscillator from the crystal path |
| ext_clk_i | input | 1 | External frequency input |
| src_ext_i | input | 1 | Source select: 1 external, 0 crystal |
| rst_req_n_i | input | 1 | Asynchronous reset request, active low |
| rdy_a_i | input | 1 | First ready request |
| rdy_a_en_n_i | input | 1 | Enable for the first request, active low |
| rdy_b_i | input | 1 | Second ready request |
| rdy_b_en_n_i | input | 1 | Enable for the second request, active low |
| rdy_dual_stage_i | input | 1 | 1 selects the two-stage READY path, 0 the single stage |
| osc_o | output | 1 | Buffered selected oscillator |
| cpu_clk_o | output | 1 | Processor clock, divide by three, one-third high |
| periph_clk_o | output | 1 | Peripheral clock, half rate, 50% duty |
| cpu_reset_o | output | 1 | Synchronised processor reset, active high |
| cpu_ready_o | output | 1 | Synchronised READY |

## Verification
The clock shapes are measured as run lengths on both oscillator sources. Any stretched or shortened phase, and any peripheral toggle that does not fall on a processor-clock rise, is caught. The ready inputs get random combinations of request and enable bits, and the stage mode is switched while they run. This separates the single-stage timing from the two-stage timing and shows whether a disabled request leaks through. Directed steps set each enable on its own against its request, which isolates the qualifier from the OR. A reset request sent at a known oscillator phase pins down the restart phase of the dividers and the latency of the reset on assertion and on release.

// File: rtl/cpu_clkgen_pkg.sv
package cpu_clkgen_pkg;
  localparam int DIV_RATIO = 3;
  localparam int CNT_W = $clog2(DIV_RATIO);

  // next state of the divide-by-ratio phase counter
  function automatic logic [CNT_W-1:0] div_next(input logic [CNT_W-1:0] cur);
    return (cur == CNT_W'(DIV_RATIO - 1)) ? '0 : cur + 1'b1;
  endfunction

  // a request counts only while its own enable (active low) is low
  function automatic logic qualify_ready(input logic req_a, input logic en_a_n,
                                         input logic req_b, input logic en_b_n);
    return (req_a & ~en_a_n) | (req_b & ~en_b_n);
  endfunction
endpackage

// File: rtl/cpu_clk_divider.sv
module cpu_clk_divider
  import cpu_clkgen_pkg::*;
(
  input  logic osc_i,
  input  logic restart_i,
  input  logic hold_i,
  output logic clk_o,
  output logic pclk_o,
  output logic rise_stb_o,
  output logic fall_stb_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt_q;
  logic clk_q;
  logic pclk_q;

  // strobes mark the oscillator edge on which the processor clock moves
  assign rise_stb_o = (cnt_q == LAST) & ~restart_i;
  assign fall_stb_o = clk_q;

  always_ff @(posedge osc_i) begin
    if (restart_i) begin
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= div_next(cnt_q);
      clk_q  <= rise_stb_o;
      pclk_q <= pclk_q ^ rise_stb_o;
    end
  end

  assign clk_o  = clk_q;
  assign pclk_o = pclk_q;

  // R1
  cnt_range_chk: assert property (@(posedge osc_i) disable iff (hold_i)
    cnt_q <= LAST);
  // R1
  clk_single_high_chk: assert property (@(posedge osc_i) disable iff (hold_i)
    clk_q |=> !clk_q);
  // R1
  clk_double_low_chk: assert property (@(posedge osc_i) disable iff (hold_i)
    $fell(clk_q) |=> !clk_q);
  // R2
  pclk_on_rise_chk: assert property (@(posedge osc_i) disable iff (hold_i)
    (pclk_q != $past(pclk_q)) |-> $rose(clk_q));
endmodule

// File: rtl/cpu_reset_sync.sv
module cpu_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic osc_i,
  input  logic req_n_i,
  input  logic fall_stb_i,
  output logic reset_o,
  output logic restart_o,
  output logic hold_o,
  output logic armed_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic seen_q;
  logic reset_q;
  logic armed_q;
  logic sync_w;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge osc_i) sync_q <= ~req_n_i;
  end else begin : g_chain
    always_ff @(posedge osc_i) sync_q <= {sync_q[STAGES-2:0], ~req_n_i};
  end

  assign sync_w    = sync_q[LAST];
  assign restart_o = sync_w & ~seen_q;
  assign hold_o    = sync_w | seen_q;

  always_ff @(posedge osc_i) begin
    seen_q  <= sync_w;
    armed_q <= armed_q | restart_o;
    if (fall_stb_i) reset_q <= sync_w;
  end

  assign reset_o = reset_q;
  assign armed_o = armed_q;

  // R5
  reset_on_fall_chk: assert property (@(posedge osc_i) disable iff (!armed_q)
    (reset_q != $past(reset_q)) |-> $past(fall_stb_i));
endmodule

// File: rtl/cpu_ready_sync.sv
module cpu_ready_sync (
  input  logic osc_i,
  input  logic req_i,
  input  logic rise_stb_i,
  input  logic fall_stb_i,
  input  logic dual_i,
  input  logic armed_i,
  output logic ready_o
);
  logic stage_a_q;
  logic stage_b_q;

  always_ff @(posedge osc_i) begin
    if (rise_stb_i) stage_a_q <= req_i;
    if (fall_stb_i) stage_b_q <= stage_a_q;
  end

  assign ready_o = dual_i ? stage_b_q : stage_a_q;

  // R8
  single_on_rise_chk: assert property (@(posedge osc_i) disable iff (!armed_i)
    (!dual_i && $stable(dual_i) && (ready_o != $past(ready_o))) |-> $past(rise_stb_i));
  // R9
  dual_on_fall_chk: assert property (@(posedge osc_i) disable iff (!armed_i)
    (dual_i && $stable(dual_i) && (ready_o != $past(ready_o))) |-> $past(fall_stb_i));
endmodule

// File: rtl/cpu_clock_reset_gen.sv
module cpu_clock_reset_gen
  import cpu_clkgen_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic xtal_clk_i,
  input  logic ext_clk_i,
  input  logic src_ext_i,
  input  logic rst_req_n_i,
  input  logic rdy_a_i,
  input  logic rdy_a_en_n_i,
  input  logic rdy_b_i,
  input  logic rdy_b_en_n_i,
  input  logic rdy_dual_stage_i,
  output logic osc_o,
  output logic cpu_clk_o,
  output logic periph_clk_o,
  output logic cpu_reset_o,
  output logic cpu_ready_o
);
  logic osc_w;
  logic restart_w;
  logic hold_w;
  logic armed_w;
  logic rise_stb_w;
  logic fall_stb_w;
  logic ready_req_w;

  // R3: source select
  assign osc_w = src_ext_i ? ext_clk_i : xtal_clk_i;
  assign osc_o = osc_w;

  // R7
  assign ready_req_w = qualify_ready(rdy_a_i, rdy_a_en_n_i, rdy_b_i, rdy_b_en_n_i);

  cpu_reset_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .osc_i      (osc_w),
    .req_n_i    (rst_req_n_i),
    .fall_stb_i (fall_stb_w),
    .reset_o    (cpu_reset_o),
    .restart_o  (restart_w),
    .hold_o     (hold_w),
    .armed_o    (armed_w)
  );

  cpu_clk_divider u_div (
    .osc_i      (osc_w),
    .restart_i  (restart_w),
    .hold_i     (hold_w),
    .clk_o      (cpu_clk_o),
    .pclk_o     (periph_clk_o),
    .rise_stb_o (rise_stb_w),
    .fall_stb_o (fall_stb_w)
  );

  cpu_ready_sync u_rdy (
    .osc_i      (osc_w),
    .req_i      (ready_req_w),
    .rise_stb_i (rise_stb_w),
    .fall_stb_i (fall_stb_w),
    .dual_i     (rdy_dual_stage_i),
    .armed_i    (armed_w),
    .ready_o    (cpu_ready_o)
  );
endmodule

// File: tb/test_cpu_clock_reset_gen.sv
module test_cpu_clock_reset_gen;
  logic xtal_clk = 1'b0;
  logic ext_clk  = 1'b0;
  always #4  xtal_clk = ~xtal_clk;
  always #12 ext_clk  = ~ext_clk;

  logic src_ext = 1'b0, rst_req_n = 1'b0;
  logic rdy_a = 1'b0, en_a_n = 1'b1, rdy_b = 1'b0, en_b_n = 1'b1, dual = 1'b0;
  logic osc_o, cpu_clk, pclk, cpu_rst, cpu_rdy;

  cpu_clock_reset_gen i_cpu_clock_reset_gen (
    .xtal_clk_i(xtal_clk), .ext_clk_i(ext_clk), .src_ext_i(src_ext),
    .rst_req_n_i(rst_req_n), .rdy_a_i(rdy_a), .rdy_a_en_n_i(en_a_n),
    .rdy_b_i(rdy_b), .rdy_b_en_n_i(en_b_n), .rdy_dual_stage_i(dual),
    .osc_o(osc_o), .cpu_clk_o(cpu_clk), .periph_clk_o(pclk),
    .cpu_reset_o(cpu_rst), .cpu_ready_o(cpu_rdy)
  );

  int n_checks = 0, n_fail = 0;
  bit use_ext = 0, done = 0;
  bit meas_on = 0, r5_on = 0, rdy_on = 0;
  bit prev_clk = 0, prev_pclk = 0, prev_rst = 0;
  int run_clk = -1, run_pclk = -1;
  bit exp_a = 0, exp_b = 0, va = 0, vb = 0;

  function automatic bit model_req(bit a, bit ea, bit b, bit eb);
    return (a && !ea) || (b && !eb);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic observe();
    bit c, p, r, req;
    c = cpu_clk; p = pclk; r = cpu_rst;
    req = model_req(rdy_a, en_a_n, rdy_b, en_b_n);
    if (meas_on) begin
      if (c != prev_clk) begin
        if (run_clk >= 0) begin
          if (prev_clk) chk(run_clk == 1, "R1 high time", run_clk, 1);
          else          chk(run_clk == 2, "R1 low time", run_clk, 2);
        end
        run_clk = 1;
      end else if (run_clk >= 0) run_clk++;
      if (p != prev_pclk) begin
        chk(c && !prev_clk, "R2 toggle on clk rise", c, 1);
        if (run_pclk >= 0) chk(run_pclk == 3, "R2 half period", run_pclk, 3);
        run_pclk = 1;
      end else if (run_pclk >= 0) run_pclk++;
    end
    if (r5_on && (r != prev_rst)) chk(prev_clk && !c, "R5 reset moves on clk fall", c, 0);
    if (rdy_on) begin
      if (c && !prev_clk) begin exp_a = req; va = 1; end
      else if (!c && prev_clk && va) begin exp_b = exp_a; vb = 1; end
      if (dual && vb) chk(cpu_rdy == exp_b, "R9 dual-stage ready", cpu_rdy, exp_b);
      if (!dual && va) chk(cpu_rdy == exp_a, "R8 single-stage ready", cpu_rdy, exp_a);
    end
    prev_clk = c; prev_pclk = p; prev_rst = r;
  endtask

  task automatic tick();
    if (use_ext) @(negedge ext_clk); else @(negedge xtal_clk);
    #1;
    observe();
  endtask

  task automatic drive_rand();
    logic [3:0] v;
    v = 4'($urandom_range(0, 15));
    {rdy_a, en_a_n, rdy_b, en_b_n} = v;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  task automatic r7_case(bit a, bit ea, bit b, bit eb, bit expv);
    {rdy_a, en_a_n, rdy_b, en_b_n} = {a, ea, b, eb};
    repeat (8) tick();
    chk(cpu_rdy == expv, "R7 qualified request", cpu_rdy, expv);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0C1C_5EED));
    // R3 crystal path: at ext-negedge+5 the crystal is high
    @(negedge ext_clk); #5;
    chk(osc_o == 1'b1, "R3 crystal selected high", osc_o, 1);
    @(posedge ext_clk); #5;
    chk(osc_o == 1'b0, "R3 crystal selected low", osc_o, 0);

    repeat (12) tick();
    chk(cpu_rst == 1'b1, "R4 reset held while request low", cpu_rst, 1);
    r5_on = 1;

    // R4 release latency
    rst_req_n = 1'b1;
    tick(); tick();
    chk(cpu_rst == 1'b1, "R4 reset still high two edges after release", cpu_rst, 1);
    repeat (3) tick();
    chk(cpu_rst == 1'b0, "R4 reset low by fifth edge", cpu_rst, 0);

    meas_on = 1; run_clk = -1; run_pclk = -1;
    rdy_on = 1; va = 0; vb = 0;
    for (int i = 0; i < 400; i++) begin
      tick();
      drive_rand();
      if (i % 64 == 63) dual = ~dual;
    end

    // R7 directed, single then dual stage
    for (int m = 0; m < 2; m++) begin
      dual = m[0];
      r7_case(1, 1, 0, 1, 0);
      r7_case(1, 0, 0, 1, 1);
      r7_case(0, 1, 1, 0, 1);
      r7_case(0, 0, 1, 1, 0);
      r7_case(1, 1, 1, 1, 0);
    end

    // R6 restart phase
    meas_on = 0; rdy_on = 0;
    rst_req_n = 1'b0;
    for (int s = 1; s <= 6; s++) begin
      tick();
      if (s >= 3 && s <= 5)
        chk(cpu_clk == 0 && pclk == 0, "R6 clocks low after restart", {cpu_clk, pclk}, 0);
      if (s == 6)
        chk(cpu_clk == 1 && pclk == 1, "R6 clocks rise on sixth edge", {cpu_clk, pclk}, 3);
    end
    repeat (2) tick();
    chk(cpu_rst == 1'b1, "R4 reset asserted after request", cpu_rst, 1);

    // R3 external path, switched while both clocks are low
    @(negedge ext_clk); #1;
    src_ext = 1'b1; use_ext = 1;
    repeat (4) tick();
    @(negedge ext_clk); #5;
    chk(osc_o == 1'b0, "R3 external selected low", osc_o, 0);
    @(posedge ext_clk); #5;
    chk(osc_o == 1'b1, "R3 external selected high", osc_o, 1);
    tick();
    rst_req_n = 1'b1;
    repeat (6) tick();
    chk(cpu_rst == 1'b0, "R4 reset released on external source", cpu_rst, 0);
    meas_on = 1; run_clk = -1; run_pclk = -1;
    rdy_on = 1; va = 0; vb = 0;
    for (int i = 0; i < 90; i++) begin
      tick();
      drive_rand();
      if (i == 45) dual = ~dual;
    end

    done = 1;
    summary();
    $finish;
  end
endmodule